// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the bus activity of one DMA channel. Each transfer has two bus cycles. A fetch cycle reads from the source, and a deposit cycle then writes to the destination. Each bus cycle walks through the states T1 to T4 on consecutive clocks. The sequencer asks an external arbiter for the bus and waits for a grant before it runs any bus cycles. On every clock it reports the kind of cycle in progress and the current T-state, so that separate address and data logic can act on them.

There are three pacing modes. In free-running mode, transfers repeat for as long as the channel is enabled. In source-paced mode, the asynchronous request line comes from the source device, and the device is acknowledged during the fetch. In destination-paced mode, the request comes from the destination device, and it is acknowledged during the deposit. In both paced modes, the synchronized request is looked at once per transfer, in the first state of the deposit cycle, and that sample decides whether another transfer follows. Destination pacing always adds a pause after the deposit. During the pause the bus is handed back, so another master can take it.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is high and on the first clock after it, cyc_o = 00, tstate_o = 0, bus_req_o = 0 and ack_o = 0.
- R2: A transfer is four fetch states (cyc_o = 01, tstate_o = 0,1,2,3) followed by four deposit states (cyc_o = 10, tstate_o = 0,1,2,3) on consecutive clocks. bus_req_o is high in all eight states.
- R3: In the bus-request state (cyc_o = 00, bus_req_o = 1), no fetch begins while bus_grant_i is low. Fetch T1 appears on the clock after bus_grant_i is seen high.
- R4: mode_i = 01 selects source pacing and mode_i = 10 selects destination pacing. From idle with the channel enabled, a request raised on dreq_i gives fetch T1 four clocks later when the grant is already high. This covers two synchronizer stages, one bus-request clock and one grant clock.
- R5: In source pacing, if the synchronized request is low during deposit T1, the channel goes idle after deposit T4 (cyc_o = 00, bus_req_o = 0). A request dropped on the clock after fetch T3 is therefore seen, and one dropped after fetch T4 is too late.
- R6: In source pacing, if the synchronized request is high during deposit T1, the next fetch T1 follows deposit T4 directly, and bus_req_o stays high.
- R7: In destination pacing, every deposit T4 is followed by exactly two release clocks (cyc_o = 11, bus_req_o = 0). After them the channel requests the bus again if the request was sampled high, and otherwise it goes idle.
- R8: mode_i = 00 or 11 selects free running. The channel starts two clocks after it is enabled, repeats transfers back to back, ignores dreq_i and never raises ack_o.
- R9: ack_o is high during fetch T1 to T4 in source pacing and during deposit T1 to T4 in destination pacing, and it is low at all other times.
- R10: When chan_en_i is cleared during a transfer, the current deposit still completes, and no further fetch follows. While chan_en_i is low, an idle channel stays idle even if the request is high.
- R11: mode_i is captured when the channel leaves idle. Changing it during a run of transfers has no effect until the channel is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en_i | input | 1 | Channel enable |
| mode_i | input | 2 | Pacing mode: 00/11 free, 01 source, 10 destination |
| dreq_i | input | 1 | Asynchronous transfer request |
| bus_grant_i | input | 1 | Bus grant from the arbiter |
| bus_req_o | output | 1 | Bus request / ownership indication |
| ack_o | output | 1 | Acknowledge to the pacing device |
| cyc_o | output | 2 | Cycle kind: 00 none, 01 fetch, 10 deposit, 11 release |
| tstate_o | output | TW | T-state index (0 = T1) within the current bus cycle |

## Verification
All outputs are registered from the next-state logic, so each output changes on the edge that moves the state. A change on dreq_i reaches the state machine two edges after it is driven. The bench drives and samples on the falling edge. It counts these edges when it checks start latency: four samples from a request to fetch T1, and two from an enable in free running. It drops the request after a specific fetch state, either T3 or T4, to check where the deposit T1 sampling point falls. After the eighth state of a transfer, it checks the very next sample for a back-to-back fetch, a release clock or idle. In the grant test, it checks that fetch T1 appears exactly one sample after the grant rises.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BUSREQ,
    S_FETCH,
    S_DEPOSIT,
    S_RELEASE
  } seq_state_e;

  localparam logic [1:0] CYC_NONE    = 2'b00;
  localparam logic [1:0] CYC_FETCH   = 2'b01;
  localparam logic [1:0] CYC_DEPOSIT = 2'b10;
  localparam logic [1:0] CYC_RELEASE = 2'b11;

  localparam logic [1:0] MODE_SRC = 2'b01;
  localparam logic [1:0] MODE_DST = 2'b10;

  function automatic logic is_free(input logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int T_STATES   = 4,
  parameter int GAP_STATES = 2,
  localparam int TW = $clog2(T_STATES),
  localparam int GW = $clog2(GAP_STATES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic [1:0]     mode_i,
  input  logic           sreq_i,
  input  logic           grant_i,
  output seq_state_e     st_n,
  output logic [TW-1:0]  tcnt_n,
  output logic [1:0]     mode_n
);
  localparam logic [TW-1:0] T_LAST = TW'(T_STATES - 1);
  localparam logic [GW-1:0] G_LAST = GW'(GAP_STATES - 1);

  seq_state_e    st_q;
  logic [TW-1:0] tcnt_q;
  logic [GW-1:0] gcnt_q, gcnt_n;
  logic          more_q, more_n;
  logic [1:0]    mode_q;

  always_comb begin
    st_n   = st_q;
    tcnt_n = tcnt_q;
    gcnt_n = gcnt_q;
    more_n = more_q;
    mode_n = mode_q;
    case (st_q)
      S_IDLE: begin
        if (en_i && (is_free(mode_i) || sreq_i)) begin
          st_n   = S_BUSREQ;
          mode_n = mode_i;
        end
      end
      S_BUSREQ: begin
        if (grant_i) begin
          st_n   = S_FETCH;
          tcnt_n = '0;
        end
      end
      S_FETCH: begin
        if (tcnt_q == T_LAST) begin
          st_n   = S_DEPOSIT;
          tcnt_n = '0;
        end else begin
          tcnt_n = tcnt_q + 1'b1;
        end
      end
      S_DEPOSIT: begin
        if (tcnt_q == '0) more_n = is_free(mode_q) | sreq_i;
        if (tcnt_q == T_LAST) begin
          tcnt_n = '0;
          if (mode_q == MODE_DST) begin
            st_n   = S_RELEASE;
            gcnt_n = '0;
          end else if (en_i && more_q) begin
            st_n = S_FETCH;
          end else begin
            st_n = S_IDLE;
          end
        end else begin
          tcnt_n = tcnt_q + 1'b1;
        end
      end
      S_RELEASE: begin
        if (gcnt_q == G_LAST) st_n = (en_i && more_q) ? S_BUSREQ : S_IDLE;
        else                  gcnt_n = gcnt_q + 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
      gcnt_q <= '0;
      more_q <= 1'b0;
      mode_q <= 2'b00;
    end else begin
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      gcnt_q <= gcnt_n;
      more_q <= more_n;
      mode_q <= mode_n;
    end
  end

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_BUSREQ && !grant_i) |=> st_q == S_BUSREQ);

  // R7
  release_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RELEASE && gcnt_q == G_LAST && !more_q) |=> st_q == S_IDLE);
endmodule

// File: rtl/dma_seq_outreg.sv
module dma_seq_outreg
  import dma_seq_pkg::*;
#(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_e    st_n,
  input  logic [TW-1:0] tcnt_n,
  input  logic [1:0]    mode_n,
  output logic [1:0]    cyc_o,
  output logic [TW-1:0] tst_o,
  output logic          req_o,
  output logic          ack_o
);
  logic [1:0]    cyc_d;
  logic [TW-1:0] tst_d;
  logic          req_d, ack_d;

  always_comb begin
    cyc_d = CYC_NONE;
    tst_d = '0;
    req_d = 1'b0;
    ack_d = 1'b0;
    case (st_n)
      S_BUSREQ: req_d = 1'b1;
      S_FETCH: begin
        cyc_d = CYC_FETCH;
        tst_d = tcnt_n;
        req_d = 1'b1;
        ack_d = (mode_n == MODE_SRC);
      end
      S_DEPOSIT: begin
        cyc_d = CYC_DEPOSIT;
        tst_d = tcnt_n;
        req_d = 1'b1;
        ack_d = (mode_n == MODE_DST);
      end
      S_RELEASE: cyc_d = CYC_RELEASE;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_o <= CYC_NONE;
      tst_o <= '0;
      req_o <= 1'b0;
      ack_o <= 1'b0;
    end else begin
      cyc_o <= cyc_d;
      tst_o <= tst_d;
      req_o <= req_d;
      ack_o <= ack_d;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int T_STATES    = 4,
  parameter int GAP_STATES  = 2,
  parameter int SYNC_STAGES = 2,
  localparam int TW = $clog2(T_STATES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_en_i,
  input  logic [1:0]    mode_i,
  input  logic          dreq_i,
  input  logic          bus_grant_i,
  output logic          bus_req_o,
  output logic          ack_o,
  output logic [1:0]    cyc_o,
  output logic [TW-1:0] tstate_o
);
  localparam logic [TW-1:0] T_LAST = TW'(T_STATES - 1);

  logic          sreq;
  seq_state_e    st_n;
  logic [TW-1:0] tcnt_n;
  logic [1:0]    mode_n;

  dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(dreq_i), .sync_o(sreq)
  );

  dma_seq_fsm #(.T_STATES(T_STATES), .GAP_STATES(GAP_STATES)) u_fsm (
    .clk(clk), .rst(rst), .en_i(chan_en_i), .mode_i(mode_i),
    .sreq_i(sreq), .grant_i(bus_grant_i),
    .st_n(st_n), .tcnt_n(tcnt_n), .mode_n(mode_n)
  );

  dma_seq_outreg #(.TW(TW)) u_out (
    .clk(clk), .rst(rst), .st_n(st_n), .tcnt_n(tcnt_n), .mode_n(mode_n),
    .cyc_o(cyc_o), .tst_o(tstate_o), .req_o(bus_req_o), .ack_o(ack_o)
  );

  // R9
  ack_owner_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> bus_req_o);

  // R7
  release_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_o == CYC_RELEASE) |-> !bus_req_o);

  // R2
  tstep_chk: assert property (@(posedge clk) disable iff (rst)
    ((cyc_o == CYC_FETCH || cyc_o == CYC_DEPOSIT) && tstate_o != T_LAST)
    |=> (cyc_o == $past(cyc_o)) && (tstate_o == $past(tstate_o) + 1'b1));

  // R2
  fetch_to_dep_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_o == CYC_FETCH && tstate_o == T_LAST)
    |=> (cyc_o == CYC_DEPOSIT && tstate_o == '0));

  // R10
  en_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_o == CYC_DEPOSIT && tstate_o == T_LAST && !chan_en_i)
    |=> cyc_o != CYC_FETCH);
endmodule

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [1:0] mode;
  logic       dreq;
  logic       grant;
  logic       bus_req, ack;
  logic [1:0] cyc;
  logic [1:0] tst;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_chan_seq u0 (
    .clk(clk), .rst(rst), .chan_en_i(en), .mode_i(mode), .dreq_i(dreq),
    .bus_grant_i(grant), .bus_req_o(bus_req), .ack_o(ack),
    .cyc_o(cyc), .tstate_o(tst)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(string tag, int c, int r, int a);
    chk({tag, " cyc"}, cyc, c);
    chk({tag, " req"}, bus_req, r);
    chk({tag, " ack"}, ack, a);
  endtask

  task automatic wait_f1(int lim, output int waited);
    waited = 0;
    while (!(cyc == 2'b01 && tst == 2'd0) && waited < lim) begin
      tick();
      waited++;
    end
  endtask

  // Walks the eight states of one transfer starting at fetch T1; ends on deposit T4.
  task automatic follow(string tag, bit ackf, bit ackd, int drop_at, int enoff_at, int flip_at);
    for (int i = 0; i < 8; i++) begin
      chk({tag, " R2 cyc"}, cyc, (i < 4) ? 1 : 2);
      chk({tag, " R2 tstate"}, tst, i % 4);
      chk({tag, " R2 req"}, bus_req, 1);
      chk({tag, " R9 ack"}, ack, (i < 4) ? ackf : ackd);
      if (i == drop_at)  dreq = 1'b0;
      if (i == enoff_at) en = 1'b0;
      if (i == flip_at)  mode = 2'b10;
      if (i < 7) tick();
    end
  endtask

  task automatic settle();
    en = 1'b0; dreq = 1'b0; grant = 1'b1;
    repeat (4) tick();
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b0; mode = 2'b00; dreq = 1'b0; grant = 1'b1;
    repeat (3) tick();
    expect_out("R1 in reset", 0, 0, 0);
    chk("R1 in reset tstate", tst, 0);
    rst = 1'b0;
    tick();
    expect_out("R1 after reset", 0, 0, 0);
    chk("R1 after reset tstate", tst, 0);
  endtask

  task automatic t_src_single();
    int w;
    mode = 2'b01; en = 1'b1;
    tick();
    expect_out("R10 no request idle", 0, 0, 0);
    dreq = 1'b1;
    wait_f1(20, w);
    chk("R4 start latency", w, 4);
    follow("R5 src single", 1, 0, 2, -1, -1);
    tick();
    expect_out("R5 idle after D4", 0, 0, 0);
    repeat (3) tick();
    expect_out("R5 stays idle", 0, 0, 0);
    settle();
  endtask

  task automatic t_src_b2b();
    int w;
    mode = 2'b01; en = 1'b1; dreq = 1'b1;
    wait_f1(20, w);
    follow("R6 src first", 1, 0, 3, -1, -1);
    tick();
    chk("R6 b2b fetch T1 cyc", cyc, 1);
    chk("R6 b2b fetch T1 tstate", tst, 0);
    chk("R6 b2b req held", bus_req, 1);
    follow("R5 src second", 1, 0, 2, -1, -1);
    tick();
    expect_out("R5 idle after second", 0, 0, 0);
    settle();
  endtask

  task automatic t_dst();
    int w;
    mode = 2'b10; en = 1'b1; dreq = 1'b1;
    wait_f1(20, w);
    chk("R4 dst start latency", w, 4);
    follow("R9 dst first", 0, 1, -1, -1, -1);
    tick();
    expect_out("R7 release 1", 3, 0, 0);
    grant = 1'b0;
    tick();
    expect_out("R7 release 2", 3, 0, 0);
    tick();
    expect_out("R7 re-request", 0, 1, 0);
    tick();
    expect_out("R3 wait grant", 0, 1, 0);
    tick();
    expect_out("R3 still waiting", 0, 1, 0);
    grant = 1'b1;
    tick();
    chk("R3 fetch after grant cyc", cyc, 1);
    chk("R3 fetch after grant tstate", tst, 0);
    follow("R7 dst second", 0, 1, 2, -1, -1);
    tick();
    expect_out("R7 release a", 3, 0, 0);
    tick();
    expect_out("R7 release b", 3, 0, 0);
    tick();
    expect_out("R7 idle after release", 0, 0, 0);
    tick();
    expect_out("R7 stays idle", 0, 0, 0);
    settle();
  endtask

  task automatic t_free();
    int w;
    mode = 2'b00; dreq = 1'b0; en = 1'b1;
    wait_f1(20, w);
    chk("R8 free start latency", w, 2);
    follow("R8 free first", 0, 0, -1, -1, -1);
    tick();
    chk("R8 free b2b cyc", cyc, 1);
    chk("R8 free b2b tstate", tst, 0);
    follow("R10 free en off", 0, 0, -1, 5, -1);
    tick();
    expect_out("R10 idle after en off", 0, 0, 0);
    settle();
    mode = 2'b11; en = 1'b1;
    wait_f1(20, w);
    chk("R8 mode 11 start latency", w, 2);
    follow("R8 mode 11", 0, 0, -1, 0, -1);
    tick();
    expect_out("R8 mode 11 stop", 0, 0, 0);
    settle();
  endtask

  task automatic t_en_src();
    int w;
    mode = 2'b01; en = 1'b1; dreq = 1'b1;
    wait_f1(20, w);
    follow("R10 src en off", 1, 0, -1, 1, -1);
    tick();
    expect_out("R10 idle, request still high", 0, 0, 0);
    repeat (4) tick();
    expect_out("R10 disabled stays idle", 0, 0, 0);
    settle();
  endtask

  task automatic t_mode_latch();
    int w;
    mode = 2'b01; en = 1'b1; dreq = 1'b1;
    wait_f1(20, w);
    follow("R11 flip mid run", 1, 0, 3, -1, 1);
    tick();
    expect_out("R11 no release inserted", 1, 1, 1);
    follow("R11 still source", 1, 0, 2, -1, -1);
    tick();
    expect_out("R11 idle", 0, 0, 0);
    settle();
    mode = 2'b01;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_src_single();
    t_src_b2b();
    t_dst();
    t_free();
    t_en_src();
    t_mode_latch();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule